// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block is a clock-synchronous behavioural model of the control side of an asynchronous parallel NOR flash with 512K words of 16 bits. It samples the active-low chip-select, read-strobe, write-strobe, power-down and protect pins once per clock. It turns two-step write sequences into program and block-erase operations and checks each one against block protection. It also keeps a sticky status word and picks what a read returns: stored words, the status word or two identifier words.

A write is taken when the write strobe rises while chip select is low. The address and data used are the values that were on the pins while the strobe was low. A small backing store and a fixed-length busy period stand in for the cell array. The store keeps only the low address bits of each block's offset, so offsets that differ only above those bits share a word. The data bus is split into an input, an output and an output-enable, as a pad ring would wire a bidirectional pin.

Top module: `norflash_cmd_front`

## Requirements
- R1: After `rst`, or while `rp_n` is low, reads come from the stored array, the status word is 0x0080 and any running operation is dropped. While `rp_n` is low, `dq_oe` stays 0. When `rp_n` returns high, reads return array words with no command needed.
- R2: `dq_oe` is 1 only when `ce_n`, `oe_n` are low and `rp_n` is high. A value applied before rising edge k appears on `dq_oe`/`dq_o` after edge k+1. When `dq_oe` is 0, `dq_o` is 0.
- R3: A bus write is taken only when `we_n` rises while `ce_n` is low. It uses `addr`/`dq_i` from the cycle before the rise. Strobes with `ce_n` high are ignored. Commands decode `dq_i[7:0]`.
- R4: Writing 0x40 and then a data write stores `dq_i` at that write's address after BUSY_CYC clocks. Reads in array mode (entered by 0xFF) then return that word.
- R5: Writing 0x20 and then 0xD0 erases the block that holds the confirm address. Every word of the block then reads 0xFFFF. Blocks 0..14 are the 32K-word regions `addr[18:15]`=0..14. The top 32K words form eight 4K-word blocks selected by `addr[14:12]`. Words that differ only in offset bits at or above OFS_AW share storage.
- R6: While `wp_n` is low, a program aimed at `addr[18:13]`=all ones sets status bits 1 and 4, and an erase aimed there sets bits 1 and 5. The array is left unchanged. All other blocks, and every block while `wp_n` is high, accept program and erase.
- R7: An erase setup followed by any byte other than 0xD0 sets status bits 4 and 5 and erases nothing.
- R8: Status bit 7 is 1 when ready and 0 for BUSY_CYC clocks while an operation runs. Bits 5 (erase error), 4 (program error) and 1 (protect error) hold the errors, and all other bits read 0. Writes made while busy are ignored. After 0x40, 0x20 or 0x70, reads return the status word.
- R9: Error bits are sticky. Only the 0x50 command or R1's reset clears them.
- R10: After 0x90, reads return MFR_ID when `addr[0]`=0 and DEV_ID when `addr[0]`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| rp_n | input | 1 | Reset / power-down, active low |
| wp_n | input | 1 | Protect control for the top two 4K blocks, active low |
| addr | input | 19 | Word address |
| dq_i | input | 16 | Data bus, input half |
| dq_o | output | 16 | Data bus, output half |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench erases and then programs every stored offset of a low main block, a parameter block and a protected block. It reads every word back against values computed from the block and offset, and checks the aliased offsets too. A design that decoded blocks wrongly or mishandled the erase counter would leave stale words or overwrite a neighbouring block. The protect boundary is probed from both sides with `wp_n` low. A wrong decode would let the lowest protected block be changed, or would refuse the unprotected block just below it. The bench also checks an illegal erase confirm, writes made during busy, strobes with chip select high, sticky errors across commands, and release from power-down. A design that got these wrong would show a changed array, a lost or wrongly cleared error bit, or a read mode left over from before power-down.

// File: rtl/norflash_pkg.sv
package norflash_pkg;

  typedef enum logic [1:0] {
    ST_READY,
    ST_PSETUP,
    ST_ESETUP,
    ST_BUSY
  } cui_state_e;

  typedef enum logic [1:0] {
    RD_ARRAY,
    RD_STATUS,
    RD_IDENT
  } rd_sel_e;

  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_IDENT   = 8'h90;

endpackage

// File: rtl/norflash_pin_sync.sv
module norflash_pin_sync #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rp_n,
  input  logic          wp_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic          ce_q,
  output logic          oe_q,
  output logic          rp_q,
  output logic          wp_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] dq_q,
  output logic          wr_evt
);

  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      rp_q   <= 1'b0;
      wp_q   <= 1'b0;
      addr_q <= '0;
      dq_q   <= '0;
    end else begin
      ce_q   <= ce_n;
      oe_q   <= oe_n;
      we_q   <= we_n;
      rp_q   <= rp_n;
      wp_q   <= wp_n;
      addr_q <= addr;
      dq_q   <= dq_i;
    end
  end

  // Rising strobe: low last cycle, high now, chip selected while it was low.
  assign wr_evt = rp_q && !ce_q && !we_q && we_n;

endmodule

// File: rtl/norflash_store.sv
module norflash_store #(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int MAIN_AW  = 15,
  parameter int PARAM_AW = 12,
  parameter int OFS_AW   = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int NMAIN  = (1 << (AW - MAIN_AW)) - 1;
  localparam int NPARAM = 1 << (MAIN_AW - PARAM_AW);
  localparam int BID_W  = $clog2(NMAIN + NPARAM);
  localparam int IDX_W  = BID_W + OFS_AW;
  localparam int DEPTH  = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [IDX_W-1:0] word_idx(input logic [AW-1:0] a);
    logic [BID_W-1:0] b;
    if (&a[AW-1:MAIN_AW])
      b = BID_W'(NMAIN) + BID_W'(a[MAIN_AW-1:PARAM_AW]);
    else
      b = BID_W'(a[AW-1:MAIN_AW]);
    return {b, a[OFS_AW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[word_idx(waddr)] <= wdata;
    rdata <= mem[word_idx(raddr)];
  end

endmodule

// File: rtl/norflash_cui.sv
module norflash_cui
  import norflash_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int PARAM_AW = 12,
  parameter int OFS_AW   = 3,
  parameter int BUSY_CYC = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rp_q,
  input  logic          wp_q,
  input  logic          wr_evt,
  input  logic [AW-1:0] evt_addr,
  input  logic [DW-1:0] evt_data,
  output rd_sel_e       rd_sel,
  output logic [DW-1:0] status,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [DW-1:0] arr_wdata
);

  localparam int CNT_W       = $clog2(BUSY_CYC);
  localparam int ERASE_WORDS = 1 << OFS_AW;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYC - 1);

  cui_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]  op_addr;
  logic [DW-1:0]  op_data;
  logic           op_erase;
  logic           err_lock, err_prog, err_erase;
  logic           frst, locked, ready, clr_hit;
  logic [7:0]     cmd;

  assign frst    = rst || !rp_q;
  assign cmd     = evt_data[7:0];
  assign locked  = (&evt_addr[AW-1:PARAM_AW+1]) && !wp_q;
  assign ready   = (state != ST_BUSY);
  assign clr_hit = (state == ST_READY) && wr_evt && (cmd == CMD_CLEAR);

  always_ff @(posedge clk) begin
    if (frst) begin
      state     <= ST_READY;
      rd_sel    <= RD_ARRAY;
      cnt       <= '0;
      op_addr   <= '0;
      op_data   <= '0;
      op_erase  <= 1'b0;
      err_lock  <= 1'b0;
      err_prog  <= 1'b0;
      err_erase <= 1'b0;
    end else begin
      unique case (state)
        ST_READY: if (wr_evt) begin
          unique case (cmd)
            CMD_READ:   rd_sel <= RD_ARRAY;
            CMD_STATUS: rd_sel <= RD_STATUS;
            CMD_IDENT:  rd_sel <= RD_IDENT;
            CMD_PROG:   begin rd_sel <= RD_STATUS; state <= ST_PSETUP; end
            CMD_ERASE:  begin rd_sel <= RD_STATUS; state <= ST_ESETUP; end
            CMD_CLEAR:  begin err_lock <= 1'b0; err_prog <= 1'b0; err_erase <= 1'b0; end
            default: ;
          endcase
        end
        ST_PSETUP: if (wr_evt) begin
          if (locked) begin
            err_lock <= 1'b1;
            err_prog <= 1'b1;
            state    <= ST_READY;
          end else begin
            op_addr  <= evt_addr;
            op_data  <= evt_data;
            op_erase <= 1'b0;
            cnt      <= '0;
            state    <= ST_BUSY;
          end
        end
        ST_ESETUP: if (wr_evt) begin
          if (cmd != CMD_CONFIRM) begin
            err_prog  <= 1'b1;
            err_erase <= 1'b1;
            state     <= ST_READY;
          end else if (locked) begin
            err_lock  <= 1'b1;
            err_erase <= 1'b1;
            state     <= ST_READY;
          end else begin
            op_addr  <= evt_addr;
            op_erase <= 1'b1;
            cnt      <= '0;
            state    <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (cnt == LAST) state <= ST_READY;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= ST_READY;
      endcase
    end
  end

  // Erase walks the stored offsets one per cycle; program commits on the last cycle.
  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = op_addr;
    arr_wdata = op_data;
    if (state == ST_BUSY) begin
      if (op_erase) begin
        arr_we    = (int'(cnt) < ERASE_WORDS);
        arr_waddr = {op_addr[AW-1:OFS_AW], cnt[OFS_AW-1:0]};
        arr_wdata = '1;
      end else begin
        arr_we = (cnt == LAST);
      end
    end
  end

  assign status = DW'({ready, 1'b0, err_erase, err_prog, 2'b00, err_lock, 1'b0});

  a_r6_lock_prog: assert property (@(posedge clk) disable iff (frst)
    (state == ST_PSETUP && wr_evt && locked) |=> (err_lock && err_prog && state == ST_READY));

  a_r6_lock_erase: assert property (@(posedge clk) disable iff (frst)
    (state == ST_ESETUP && wr_evt && cmd == CMD_CONFIRM && locked) |=> (err_lock && err_erase && !arr_we));

  a_r7_bad_confirm: assert property (@(posedge clk) disable iff (frst)
    (state == ST_ESETUP && wr_evt && cmd != CMD_CONFIRM) |=> (err_prog && err_erase && state == ST_READY));

  a_r9_sticky_lock: assert property (@(posedge clk) disable iff (frst)
    (!$past(frst) && $fell(err_lock)) |-> $past(clr_hit));

  a_r8_busy_len: assert property (@(posedge clk) disable iff (frst)
    (!$past(frst) && $rose(ready)) |-> $past(cnt == LAST));

endmodule

// File: rtl/norflash_cmd_front.sv
module norflash_cmd_front
  import norflash_pkg::*;
#(
  parameter int          AW       = 19,
  parameter int          DW       = 16,
  parameter int          MAIN_AW  = 15,
  parameter int          PARAM_AW = 12,
  parameter int          OFS_AW   = 3,
  parameter int          BUSY_CYC = 16,
  parameter logic [15:0] MFR_ID   = 16'h00A5,
  parameter logic [15:0] DEV_ID   = 16'h2C5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rp_n,
  input  logic          wp_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);

  logic          ce_q, oe_q, rp_q, wp_q, wr_evt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dq_q;
  rd_sel_e       rd_sel, sel_r;
  logic [DW-1:0] status, stat_r, id_r, arr_rd;
  logic          arr_we, oe_r;
  logic [AW-1:0] arr_waddr;
  logic [DW-1:0] arr_wdata;

  norflash_pin_sync #(.AW(AW), .DW(DW)) u_sync (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
    .wp_n(wp_n), .addr(addr), .dq_i(dq_i), .ce_q(ce_q), .oe_q(oe_q), .rp_q(rp_q),
    .wp_q(wp_q), .addr_q(addr_q), .dq_q(dq_q), .wr_evt(wr_evt)
  );

  norflash_cui #(
    .AW(AW), .DW(DW), .PARAM_AW(PARAM_AW), .OFS_AW(OFS_AW), .BUSY_CYC(BUSY_CYC)
  ) u_cui (
    .clk(clk), .rst(rst), .rp_q(rp_q), .wp_q(wp_q), .wr_evt(wr_evt),
    .evt_addr(addr_q), .evt_data(dq_q), .rd_sel(rd_sel), .status(status),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  norflash_store #(
    .AW(AW), .DW(DW), .MAIN_AW(MAIN_AW), .PARAM_AW(PARAM_AW), .OFS_AW(OFS_AW)
  ) u_store (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(addr_q), .rdata(arr_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_r  <= RD_ARRAY;
      stat_r <= '0;
      id_r   <= '0;
      oe_r   <= 1'b0;
    end else begin
      sel_r  <= rd_sel;
      stat_r <= status;
      id_r   <= addr_q[0] ? DW'(DEV_ID) : DW'(MFR_ID);
      oe_r   <= rp_q && !ce_q && !oe_q;
    end
  end

  always_comb begin
    dq_o = '0;
    if (oe_r) begin
      unique case (sel_r)
        RD_STATUS: dq_o = stat_r;
        RD_IDENT:  dq_o = id_r;
        default:   dq_o = arr_rd;
      endcase
    end
  end

  assign dq_oe = oe_r;

  a_r2_drive_gate: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(rp_q && !ce_q && !oe_q));

  a_r1_rp_quiet: assert property (@(posedge clk) disable iff (rst)
    !rp_q |=> !dq_oe);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_o == '0));

endmodule

// File: tb/norflash_cmd_front_tb.sv
module norflash_cmd_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 16;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h2C5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, wp_n = 1'b1;
  logic [18:0] addr = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic        dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  norflash_cmd_front #(.BUSY_CYC(LAT), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
    .wp_n(wp_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] base(input int b);
    if (b < 15) return 19'(b << 15);
    return 19'h78000 + 19'((b - 15) << 12);
  endfunction

  function automatic logic [15:0] pat(input int b, input int o);
    return 16'((b * 16'h0133) ^ (o * 16'h0A51) ^ 16'h5A0F);
  endfunction

  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [18:0] a, output logic [15:0] d, output logic oe);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    d = dq_o; oe = dq_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_op();
    repeat (LAT + 4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    logic        oe;
    int          blks [3];
    blks[0] = 0; blks[1] = 15; blks[2] = 22;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 idle no drive", 16'(dq_oe), 16'h0);

    wr(19'h0, 16'h0070);
    rd(19'h0, d, oe);
    chk("R1 status after reset", d, 16'h0080);
    chk("R2 drive when selected", 16'(oe), 16'h1);

    // R2: only one of the two strobes low
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no drive ce high", 16'(dq_oe), 16'h0);
    chk("R2 data zero undriven", dq_o, 16'h0);
    ce_n = 1'b0; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no drive oe high", 16'(dq_oe), 16'h0);
    ce_n = 1'b1;

    // R5: erase three blocks
    foreach (blks[i]) begin
      wr(base(blks[i]), 16'h0020);
      wr(base(blks[i]) + 19'd5, 16'h00D0);
      wait_op();
      rd(base(blks[i]), d, oe);
      chk("R8 status after erase", d, 16'h0080);
      wr(19'h0, 16'h00FF);
      for (int o = 0; o < 8; o++) begin
        rd(base(blks[i]) + 19'(o), d, oe);
        chk("R5 erased word", d, 16'hFFFF);
      end
    end

    // R4 / R8: program sweep with a busy probe on the first word
    foreach (blks[i]) begin
      for (int o = 0; o < 8; o++) begin
        wr(base(blks[i]) + 19'(o), 16'h0040);
        wr(base(blks[i]) + 19'(o), pat(blks[i], o));
        if (i == 0 && o == 0) begin
          rd(19'h0, d, oe);
          chk("R8 busy status", d, 16'h0000);
          wr(19'h0, 16'h00FF);
        end
        wait_op();
        if (i == 0 && o == 0) begin
          rd(19'h0, d, oe);
          chk("R8 write during busy ignored", d, 16'h0080);
        end
      end
    end
    wr(19'h0, 16'h00FF);
    foreach (blks[i]) begin
      for (int o = 0; o < 8; o++) begin
        rd(base(blks[i]) + 19'(o), d, oe);
        chk("R4 program readback", d, pat(blks[i], o));
      end
    end
    for (int o = 0; o < 8; o++) begin
      rd(base(0) + 19'(8 + o), d, oe);
      chk("R5 offset alias", d, pat(0, o));
    end

    // R3: strobe with chip select high ignored
    @(negedge clk); addr = 19'h0; dq_i = 16'h0070; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    rd(base(0), d, oe);
    chk("R3 unselected strobe ignored", d, pat(0, 0));

    // R6: protection with wp_n low
    wp_n = 1'b0;
    wr(19'h0, 16'h0050);
    wr(base(22) + 19'd1, 16'h0040);
    wr(base(22) + 19'd1, 16'h1234);
    rd(19'h0, d, oe);
    chk("R6 locked program status", d, 16'h0092);
    wr(19'h0, 16'h00FF);
    rd(base(22) + 19'd1, d, oe);
    chk("R6 locked word unchanged", d, pat(22, 1));
    wr(19'h0, 16'h0050);
    wr(19'h0, 16'h0070);
    rd(19'h0, d, oe);
    chk("R9 clear status", d, 16'h0080);
    wr(base(22), 16'h0020);
    wr(base(22), 16'h00D0);
    rd(19'h0, d, oe);
    chk("R6 locked erase status", d, 16'h00A2);
    wr(19'h0, 16'h00FF);
    rd(base(22) + 19'd2, d, oe);
    chk("R6 locked block not erased", d, pat(22, 2));
    wr(19'h0, 16'h0070);
    rd(19'h0, d, oe);
    chk("R9 error sticky", d, 16'h00A2);
    wr(19'h0, 16'h0050);
    wr(base(21), 16'h0040);
    wr(base(21), 16'h1111);
    rd(19'h0, d, oe);
    chk("R6 lowest locked block", d, 16'h0092);
    wr(19'h0, 16'h0050);
    wr(base(20) + 19'd3, 16'h0040);
    wr(base(20) + 19'd3, 16'h0F0F);
    wait_op();
    rd(19'h0, d, oe);
    chk("R6 unlocked neighbour status", d, 16'h0080);
    wr(19'h0, 16'h00FF);
    rd(base(20) + 19'd3, d, oe);
    chk("R6 unlocked neighbour programmed", d, 16'h0F0F);
    wp_n = 1'b1;

    // R7: bad erase confirm
    wr(base(0), 16'h0020);
    wr(base(0), 16'h0033);
    wait_op();
    rd(19'h0, d, oe);
    chk("R7 bad confirm status", d, 16'h00B0);
    wr(19'h0, 16'h00FF);
    rd(base(0), d, oe);
    chk("R7 no erase", d, pat(0, 0));

    // R10: identifier words
    wr(19'h0, 16'h0090);
    rd(19'h0, d, oe);
    chk("R10 maker id", d, MFR);
    rd(19'h1, d, oe);
    chk("R10 device id", d, DEV);

    // R1: power-down and release
    @(negedge clk); rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 no drive in power-down", 16'(dq_oe), 16'h0);
    ce_n = 1'b1; oe_n = 1'b1; rp_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(base(15) + 19'd4, d, oe);
    chk("R1 array mode after release", d, pat(15, 4));
    wr(19'h0, 16'h0070);
    rd(19'h0, d, oe);
    chk("R1 status cleared by power-down", d, 16'h0080);

    summary();
    $finish;
  end

endmodule